// File: doc/BRIEF.md
# Timer match output and PWM unit

This block is a 16-bit up-counter with four compare registers. Each compare register drives one output pin. Each compare channel keeps an external-match bit. Whenever the counter equals that channel's compare value, a two-bit action code updates the bit: it can leave the bit alone, force it low, force it high or invert it. The first `NUM_PWM` channels can instead be switched to single-edge PWM. In that mode the pin goes high on the channel's compare hit and goes low when the counter restarts.

The last compare register sets the period. When the counter equals it, the counter goes back to zero on the next clock. The same clock clears every PWM-mode output at once. The period channel never runs as PWM, so its pin always follows its external-match bit. Software sets the block up through a simple synchronous write port and a combinational read port. Through these it sets the compare values, the action codes, the PWM enables and the run bit.

Top module: `tmr_match_pwm`

## Requirements
- R1: While the run bit (address 6, bit 0) is 1, the counter increments by one each clock. On the clock after it equals the period register (address 3), it becomes 0 instead. After reset it is 0.
- R2: The action field for channel m sits in bits [2m+1:2m] of address 4. On a clock where the counter equals channel m's compare value, the field updates the channel's external-match bit: 00 leaves it unchanged, 01 clears it, 10 sets it and 11 inverts it. The bit is updated in both output modes and is 0 after reset.
- R3: Bit m of address 5 selects the mode of channel m (m < NUM_PWM). With the bit at 1 the pin shows the PWM state; with it at 0 the pin shows the external-match bit. All enable bits are 0 after reset.
- R4: On the clock after the counter equals a PWM channel's compare value, that channel's PWM state goes high. This holds only if the compare value is nonzero and no greater than the period value.
- R5: On the clock where the counter returns to 0, every PWM state goes low. If a channel's set and the clear fall on the same clock, the clear wins, so a channel whose compare value equals the period stays low.
- R6: A PWM channel whose compare value is 0, or greater than the period value, stays low for the whole run.
- R7: Address 4 keeps only bits [7:0] and address 5 keeps only bits [NUM_PWM-1:0]. Written upper bits are dropped and read back as 0. The period channel (channel 3) never enters PWM mode.
- R8: While the run bit is 0, the counter holds its value, no compare hit occurs and every pin keeps its value.
- R9: Addresses 0 to 3 hold the 16-bit compare values of channels 0 to 3, and each reads back what was written. Unassigned addresses read as 0.
- R10: A compare value written while running is used from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 16 | Read data for rdAddr, combinational |
| matchOut | output | 4 | Channel output pins |

## Verification
The PWM function is driven with a spread of compare values: values below the period, a zero compare, a compare equal to the period and one above it. These separate a correct set with a wrap-time clear from a missing clear-over-set priority and from wrongly gated out-of-range channels. The external-match mode runs every action code at once on different channels. It is then switched to PWM and back mid-run, which shows whether the external-match bit kept updating in the background. Pausing the timer shows the counter is frozen. Rewriting a compare value mid-run and writing ones to the unused register bits cover the live-update path and the dropped-bit cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W      = 16;
  localparam int MATCH_N    = 4;
  localparam int PERIOD_IDX = MATCH_N - 1;
  localparam int ACT_W      = 2;
  localparam int ACT_BITS   = ACT_W * MATCH_N;
  localparam int ADDR_W     = 3;
  localparam int MSEL_W     = $clog2(MATCH_N);

  localparam logic [ADDR_W-1:0] ADDR_ACT = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_PWM = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_RUN = 3'd6;

  typedef enum logic [ACT_W-1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  // strobes from the compare datapath to the output control
  typedef struct packed {
    logic [MATCH_N-1:0] hit;    // counter equals compare value, timer running
    logic [MATCH_N-1:0] setOk;  // compare value lies inside (0, period]
    logic               wrap;   // period hit: counter restarts next clock
  } strobe_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int NUM_PWM = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [CNT_W-1:0]               wrData,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [CNT_W-1:0]               rdData,
  output logic [MATCH_N-1:0][CNT_W-1:0]  matchVal,
  output logic [ACT_BITS-1:0]            actCtl,
  output logic [NUM_PWM-1:0]             pwmEn,
  output logic                           timerEn
);
  for (genvar m = 0; m < MATCH_N; m++) begin : g_match
    always_ff @(posedge clk) begin
      if (!rstN) matchVal[m] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(m)) matchVal[m] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCtl  <= '0;
      pwmEn   <= '0;
      timerEn <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_ACT) actCtl  <= wrData[ACT_BITS-1:0];
      if (wrAddr == ADDR_PWM) pwmEn   <= wrData[NUM_PWM-1:0];
      if (wrAddr == ADDR_RUN) timerEn <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr < ADDR_W'(MATCH_N)) rdData = matchVal[rdAddr[MSEL_W-1:0]];
    else if (rdAddr == ADDR_ACT)   rdData = {{(CNT_W-ACT_BITS){1'b0}}, actCtl};
    else if (rdAddr == ADDR_PWM)   rdData = {{(CNT_W-NUM_PWM){1'b0}}, pwmEn};
    else if (rdAddr == ADDR_RUN)   rdData = {{(CNT_W-1){1'b0}}, timerEn};
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [MATCH_N-1:0][CNT_W-1:0] matchVal,
  input  logic                          timerEn,
  output logic [CNT_W-1:0]              cnt,
  output strobe_t                       strb
);
  logic [CNT_W-1:0] periodVal;
  assign periodVal = matchVal[PERIOD_IDX];

  for (genvar m = 0; m < MATCH_N; m++) begin : g_cmp
    assign strb.hit[m]   = timerEn && (cnt == matchVal[m]);
    assign strb.setOk[m] = (matchVal[m] != '0) && (matchVal[m] <= periodVal);
  end
  assign strb.wrap = strb.hit[PERIOD_IDX];

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (timerEn)   cnt <= strb.wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_outctl.sv
module tmr_outctl
  import tmr_pkg::*;
#(
  parameter int NUM_PWM = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [ACT_BITS-1:0] actCtl,
  input  logic [NUM_PWM-1:0]  pwmEn,
  output logic [MATCH_N-1:0]  matchOut
);
  logic [MATCH_N-1:0] emQ, emNext;
  logic [NUM_PWM-1:0] pwmQ, pwmNext;

  always_comb begin
    emNext = emQ;
    for (int m = 0; m < MATCH_N; m++) begin
      if (strb.hit[m]) begin
        case (act_e'(actCtl[ACT_W*m +: ACT_W]))
          ACT_LOW:  emNext[m] = 1'b0;
          ACT_HIGH: emNext[m] = 1'b1;
          ACT_FLIP: emNext[m] = ~emQ[m];
          default:  emNext[m] = emQ[m];
        endcase
      end
    end
  end

  always_comb begin
    pwmNext = pwmQ;
    for (int m = 0; m < NUM_PWM; m++) begin
      if (strb.wrap)                           pwmNext[m] = 1'b0;
      else if (strb.hit[m] && strb.setOk[m])   pwmNext[m] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emQ  <= '0;
      pwmQ <= '0;
    end else begin
      emQ  <= emNext;
      pwmQ <= pwmNext;
    end
  end

  for (genvar m = 0; m < MATCH_N; m++) begin : g_out
    if (m < NUM_PWM) begin : g_mux
      assign matchOut[m] = pwmEn[m] ? pwmQ[m] : emQ[m];
    end else begin : g_ext
      assign matchOut[m] = emQ[m];
    end
  end
endmodule

// File: rtl/tmr_match_pwm.sv
module tmr_match_pwm
  import tmr_pkg::*;
#(
  parameter int NUM_PWM = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [CNT_W-1:0]   rdData,
  output logic [MATCH_N-1:0] matchOut
);
  logic [MATCH_N-1:0][CNT_W-1:0] matchVal;
  logic [ACT_BITS-1:0]           actCtl;
  logic [NUM_PWM-1:0]            pwmEn;
  logic                          timerEn;
  logic [CNT_W-1:0]              cnt;
  strobe_t                       strb;

  tmr_regs #(.NUM_PWM(NUM_PWM)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .matchVal(matchVal), .actCtl(actCtl),
    .pwmEn(pwmEn), .timerEn(timerEn)
  );

  tmr_datapath i_dp (
    .clk(clk), .rstN(rstN), .matchVal(matchVal), .timerEn(timerEn),
    .cnt(cnt), .strb(strb)
  );

  tmr_outctl #(.NUM_PWM(NUM_PWM)) i_ctl (
    .clk(clk), .rstN(rstN), .strb(strb), .actCtl(actCtl), .pwmEn(pwmEn),
    .matchOut(matchOut)
  );
endmodule

// File: rtl/tmr_match_pwm_chk.sv
module tmr_match_pwm_chk
  import tmr_pkg::*;
#(
  parameter int NUM_PWM = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               timerEn,
  input logic [CNT_W-1:0]   cnt,
  input strobe_t            strb,
  input logic [NUM_PWM-1:0] pwmEn,
  input logic [MATCH_N-1:0] matchOut
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerEn && !strb.wrap) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R1
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> (cnt == '0));

  // R5
  pwm_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrap && !wrEn) |=> ((matchOut[NUM_PWM-1:0] & pwmEn) == '0));

  // R7
  period_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hit[PERIOD_IDX] |=> $stable(matchOut[PERIOD_IDX]));

  // R8
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |=> $stable(cnt));

  // R8
  hold_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !wrEn) |=> $stable(matchOut));
endmodule

bind tmr_match_pwm tmr_match_pwm_chk #(.NUM_PWM(NUM_PWM)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .timerEn(timerEn), .cnt(cnt),
  .strb(strb), .pwmEn(pwmEn), .matchOut(matchOut)
);

// File: tb/test_tmr_match_pwm.sv
module test_tmr_match_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [3:0]  matchOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // shadow of the programmed registers, per the requirements
  logic [15:0] mMatch [4];
  logic [7:0]  mAct = '0;
  logic [2:0]  mPwmEn = '0;
  logic        mEn = 1'b0;
  // expected state
  logic [15:0] refCnt = '0;
  logic [3:0]  refEm = '0;
  logic [2:0]  refPwm = '0;

  tmr_match_pwm #(.NUM_PWM(NP)) i_tmr_match_pwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .matchOut(matchOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < 4; i++) mMatch[i] = '0;

  // expected behaviour: R1 counting/wrap, R2 actions, R4/R5/R6 PWM
  always @(posedge clk) begin
    logic wrapNow;
    if (!rstN) begin
      refCnt = '0; refEm = '0; refPwm = '0;
    end else if (mEn) begin
      wrapNow = (refCnt == mMatch[3]);
      for (int m = 0; m < 4; m++)
        if (refCnt == mMatch[m])
          case (mAct[2*m +: 2])
            2'b01: refEm[m] = 1'b0;
            2'b10: refEm[m] = 1'b1;
            2'b11: refEm[m] = ~refEm[m];
            default: ;
          endcase
      for (int m = 0; m < NP; m++)
        if (wrapNow) refPwm[m] = 1'b0;
        else if (refCnt == mMatch[m] && mMatch[m] != 0 && mMatch[m] <= mMatch[3])
          refPwm[m] = 1'b1;
      refCnt = wrapNow ? 16'd0 : refCnt + 16'd1;
    end
  end

  function automatic logic [3:0] expOut();
    logic [3:0] e;
    for (int m = 0; m < 4; m++)
      e[m] = (m < NP && mPwmEn[m]) ? refPwm[m] : refEm[m];
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    if (a < 4) mMatch[a] = d;
    else if (a == 4) mAct = d[7:0];
    else if (a == 5) mPwmEn = d[2:0];
    else if (a == 6) mEn = d[0];
  endtask

  task automatic rdChk(string req, logic [2:0] a, logic [15:0] exp);
    @(negedge clk);
    rdAddr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic step(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, matchOut, expOut());
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R3 reset pins", matchOut, 4'h0);
    for (int a = 0; a < 8; a++) rdChk("R9 reset read", 3'(a), 16'h0);
  endtask

  task automatic t_regs();
    wr(0, 16'hA5C3); wr(1, 16'h1234); wr(2, 16'hFFFF); wr(3, 16'h0F0F);
    rdChk("R9 match0", 0, 16'hA5C3);
    rdChk("R9 match1", 1, 16'h1234);
    rdChk("R9 match2", 2, 16'hFFFF);
    rdChk("R9 match3", 3, 16'h0F0F);
    wr(4, 16'hFFFF);
    rdChk("R7 action upper bits", 4, 16'h00FF);
    wr(5, 16'hFFFF);
    rdChk("R7 pwm enable upper bits", 5, 16'h0007);
    rdChk("R9 unassigned", 7, 16'h0);
    wr(4, 16'h0); wr(5, 16'h0);
  endtask

  task automatic t_pwm();
    wr(0, 2); wr(1, 5); wr(2, 0); wr(3, 9);
    wr(5, 16'h000F);   // bit 3 must be dropped: R7
    wr(6, 1);
    step("R4 R5 R6 pwm pattern", 25);
    @(negedge clk);
    chk("R6 zero compare stays low", matchOut[2], 1'b0);
    chk("R7 period pin external", matchOut[3], refEm[3]);
  endtask

  task automatic t_edges();
    wr(1, 9);          // equal to period: clear wins, R5
    wr(2, 12);         // above period, R6
    step("R5 R6 equal/above period", 24);
    chk("R5 equal-period channel low", matchOut[1], 1'b0);
  endtask

  task automatic t_ext();
    wr(5, 0);
    wr(0, 1); wr(1, 4); wr(2, 6);
    wr(4, 16'h00DB);   // ch0 invert, ch1 set, ch2 clear, ch3 invert
    step("R2 external actions", 22);
    wr(4, 16'h00E7);   // ch0 invert, ch1 clear, ch2 set, ch3 invert
    step("R2 external actions 2", 22);
    wr(5, 16'h0005);
    step("R3 switch to pwm", 15);
    wr(5, 16'h0000);
    step("R3 back to external", 12);
  endtask

  task automatic t_hold();
    logic [3:0] snap;
    wr(5, 16'h0003);
    step("R8 prerun", 4);
    wr(6, 0);
    snap = matchOut;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 pins held", matchOut, snap);
    end
    wr(6, 1);
    step("R8 resume", 14);
  endtask

  task automatic t_live();
    wr(0, 7);
    step("R10 live compare update", 12);
    wr(0, 3);
    step("R10 live compare update 2", 12);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_regs();
    t_pwm();
    t_edges();
    t_ext();
    t_hold();
    t_live();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule